// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Analog Channel Sharing

This block is an 8-bit general-purpose I/O port on a simple peripheral bus. It keeps two registers: an output data latch and a per-pin direction register. The direction bits drive the pad output enables, and the latch drives the pad output values. Pin levels pass through a two-flop synchronizer before software can read them.

An analog converter shares the same pins and tells the port which one it has claimed through a 5-bit channel select. The claim only changes what software reads. A claimed pin set as an input reads as 0. A claimed pin set as an output reads its latch value. The pad enables and the direction bits do not depend on the claim, so software must set the direction of a pin used for analog sampling itself.

Writes are committed on the rising clock edge while the write strobe is high. Read data is combinational from the address and the current register state.

Top module: `gpio_analog_port`

## Requirements
- R1: After synchronous reset the direction register, the data latch, `pin_oe` and `pin_out` are all 0, so every pin is an input.
- R2: A write to address 0x05 loads the direction register. `pin_oe` shows the new value after that clock edge, where bit value 1 means output enabled. A read of 0x05 returns the register.
- R3: A write to address 0x01 loads the data latch for all eight bits, including bits whose pin is an input. `pin_out` shows the new value after that clock edge.
- R4: A pin that is an input and not claimed reads at address 0x01 as its pin level. A level change becomes visible after exactly two rising clock edges.
- R5: A pin whose direction bit is 1 and that is not claimed reads at address 0x01 as its latch bit.
- R6: A pin claimed by the channel select (select value i claims pin i, for i from 0 to 7) whose direction bit is 0 reads as 0 at address 0x01.
- R7: A claimed pin whose direction bit is 1 reads as its latch bit at address 0x01.
- R8: The channel select never changes the direction register, `pin_oe` or `pin_out`.
- R9: Channel select values 8 through 31 claim no pin, so all eight bits read as in R4 and R5.
- R10: Reads of any address other than 0x01 and 0x05 return 0. Writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, committed on the clock edge |
| bus_rdata | output | 8 | Combinational read data |
| ana_sel | input | 5 | Analog channel select from the converter |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
A corrupt direction bit shows at `pin_oe` one edge after the write that caused it. It also flips the read source of that bit at once, between latch and pin level, or between latch and forced zero. A bad latch bit shows on `pin_out` right away, and in the read data as soon as that pin is an output. A fault in the synchronizer chain shifts the first read of a new pin level by one edge or more, so the bench samples both one edge and two edges after each level change. The select decode is swept over all 32 values with several direction, latch and pin patterns. A wrong claim therefore shows as a single bit that is wrongly zero, or wrongly not zero, in the same cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DEF_PORT_W = 8;
  localparam int DEF_SEL_W  = 5;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_SYNC_N = 2;

  // Effective read value of one bit, from its direction, claim, latch and pin level
  function automatic logic bit_view(input logic dir_b, input logic claimed,
                                    input logic latch_b, input logic pin_b);
    if (dir_b)        return latch_b;
    else if (claimed) return 1'b0;
    else              return pin_b;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];

  initial begin
    if (STAGES < 2) $error("gpio_sync needs at least two stages");
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int                W         = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              wr_en,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      latch_q
);
  logic dir_we, latch_we;
  assign dir_we   = wr_en && (wr_addr == DIR_ADDR);
  assign latch_we = wr_en && (wr_addr == DATA_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_we)   dir_q   <= wr_data;
      if (latch_we) latch_q <= wr_data;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '0 && latch_q == '0)); // R1
  AST_DIR_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == DIR_ADDR) |=> (dir_q == $past(wr_data))); // R2
  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == DATA_ADDR) |=> (latch_q == $past(wr_data))); // R3
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == DIR_ADDR) |=> $stable(dir_q)); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == DATA_ADDR) |=> $stable(latch_q)); // R10
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int                W         = 8,
  parameter int                SEL_W     = 5,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEL_W-1:0]  ana_sel,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] ana_hit;
  logic [W-1:0] data_view;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign ana_hit[gi]   = (ana_sel == SEL_W'(gi));
    assign data_view[gi] = bit_view(dir_q[gi], ana_hit[gi], latch_q[gi], pin_sync[gi]);

    AST_CLAIMED_INPUT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == DATA_ADDR && ana_sel == SEL_W'(gi) && !dir_q[gi]) |-> !rdata[gi]); // R6
    AST_CLAIMED_OUTPUT_LATCH: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == DATA_ADDR && ana_sel == SEL_W'(gi) && dir_q[gi]) |-> (rdata[gi] == latch_q[gi])); // R7
    AST_FREE_INPUT_PIN: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == DATA_ADDR && ana_sel >= SEL_W'(W) && !dir_q[gi]) |-> (rdata[gi] == pin_sync[gi])); // R9
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == DATA_ADDR)     rdata = data_view;
    else if (rd_addr == DIR_ADDR) rdata = dir_q;
  end

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (rst) $onehot0(ana_hit)); // R9
endmodule

// File: rtl/gpio_analog_port.sv
module gpio_analog_port
  import gpio_port_pkg::*;
#(
  parameter int                PORT_W    = DEF_PORT_W,
  parameter int                SEL_W     = DEF_SEL_W,
  parameter int                ADDR_W    = DEF_ADDR_W,
  parameter int                SYNC_N    = DEF_SYNC_N,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [SEL_W-1:0]  ana_sel,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_out
);
  logic [PORT_W-1:0] dir_q, latch_q, pin_sync;

  gpio_regs #(.W(PORT_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_addr(bus_addr), .wr_data(bus_wdata), .wr_en(bus_we),
    .dir_q(dir_q), .latch_q(latch_q)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
  );

  gpio_read_mux #(.W(PORT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
                  .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_rmux (
    .clk(clk), .rst(rst), .rd_addr(bus_addr), .ana_sel(ana_sel), .dir_q(dir_q),
    .latch_q(latch_q), .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = latch_q;

  AST_OE_SEL_FREE: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && !$stable(ana_sel)) |=> ($stable(pin_oe) && $stable(pin_out))); // R8
endmodule

// File: tb/gpio_analog_port_test.sv
`timescale 1ns/1ps
module gpio_analog_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
  logic       bus_we = 1'b0;
  logic [4:0] ana_sel = 5'd31;
  logic [7:0] bus_rdata, pin_oe, pin_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gpio_analog_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .ana_sel(ana_sel), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    check(bus_rdata, exp, req);
  endtask

  function automatic logic [7:0] model(input logic [7:0] d, input logic [7:0] l,
                                       input logic [7:0] p, input logic [4:0] s);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = d[i] ? l[i] : ((s == 5'(i)) ? 1'b0 : p[i]);
    return r;
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    logic [7:0] dirs [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};
    logic [7:0] lats [6] = '{8'hC3, 8'h96, 8'h0F, 8'hF0, 8'h7E, 8'h24};
    logic [7:0] pins [6] = '{8'hFF, 8'h55, 8'hE1, 8'h18, 8'hB7, 8'hDB};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(pin_oe, 8'h00, "R1 pin_oe");
    check(pin_out, 8'h00, "R1 pin_out");
    rd_chk(8'h05, 8'h00, "R1 dir read");

    // R3: preload latch while all pins are inputs
    wr(8'h01, 8'hA7); #1;
    check(pin_out, 8'hA7, "R3 preload");
    check(pin_oe, 8'h00, "R3 oe unchanged");
    // R2: direction write
    wr(8'h05, 8'h0F); #1;
    check(pin_oe, 8'h0F, "R2 oe");
    rd_chk(8'h05, 8'h0F, "R2 readback");

    // R4: two-edge synchronizer latency
    ana_sel = 5'd20;
    @(negedge clk); pin_in = 8'hF0;
    @(negedge clk); bus_addr = 8'h01; #1;
    check(bus_rdata, 8'h07, "R4 one edge old");
    @(negedge clk); #1;
    check(bus_rdata, 8'hF7, "R4 two edges new");

    // R10: stray address
    wr(8'h02, 8'hFF);
    rd_chk(8'h02, 8'h00, "R10 read other");
    rd_chk(8'h05, 8'h0F, "R10 dir kept");
    check(pin_out, 8'hA7, "R10 latch kept");

    // Sweep: patterns x all 32 select values
    for (int p = 0; p < 6; p++) begin
      wr(8'h01, lats[p]);
      wr(8'h05, dirs[p]);
      @(negedge clk); pin_in = pins[p];
      repeat (3) @(negedge clk);
      for (int s = 0; s < 32; s++) begin
        @(negedge clk); ana_sel = 5'(s); bus_addr = 8'h01; #1;
        check(bus_rdata, model(dirs[p], lats[p], pins[p], 5'(s)),
              s < 8 ? "R6 R7 claimed read" : "R9 R4 R5 free read");
        check(pin_oe, dirs[p], "R8 oe");
        check(pin_out, lats[p], "R8 out");
      end
    end

    // R5 with no claim, mixed directions
    ana_sel = 5'd8;
    wr(8'h05, 8'hCC);
    rd_chk(8'h01, model(8'hCC, 8'h24, 8'hDB, 5'd8), "R5 output bits");

    // R1: reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check(pin_oe, 8'h00, "R1 second reset oe");
    check(pin_out, 8'h00, "R1 second reset out");

    done = 1;
    finish_up();
  end
endmodule